// File: doc/BRIEF.md
# Multi-Lane SPI Memory Operation Framer

The framer accepts one memory operation descriptor at a time and plays it out on a four-lane serial bus as a single transaction framed by chip select. A transaction can have up to four phases, always in the same order: a one-byte command, an address of zero to three bytes, a number of dummy bytes, and a data phase that either sends or receives bytes. The address, dummy and data phases each have their own lane width of one, two or four lanes. A phase whose byte count is zero is left out of the transaction entirely. The serial clock idles low and data is captured on its rising edge.

The descriptor port is a valid/ready handshake. The framer copies all descriptor fields on the cycle where both `desc_valid` and `desc_ready` are high, and the host may change them afterwards. Transmit data comes in as a valid/ready byte stream. When the framer needs a byte and `tx_valid` is low, it holds the serial clock low until the byte arrives, so the flow of data out is throttled by the host and never by the bus. Received bytes leave through `rx_valid`/`rx_data` as a one-cycle strobe. There is no back-pressure on this path, so the consumer must take every strobed byte. `done` pulses as chip select is released.

A lane-width code is 2 bits: 0 selects one lane, 1 selects two lanes and 2 or 3 select four lanes. The serial clock half-period is `CLK_DIV` system clocks.

Top module: `spi_op_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, `spi_cs_n`=1, `spi_sclk`=0, `io_oe`=0, `done`=0, `rx_valid`=0 and `desc_ready`=1.
- R2: Each phase transfers its bytes in the order command, address, dummy, data. A phase with a count of zero is skipped. The number of SCLK rising edges equals the sum of 8/width over all bytes sent.
- R3: The command byte always uses a single lane. It is sent MSB first on IO0 with `io_oe`=4'b0001.
- R4: The address sends the low `desc_addr_bytes` bytes of `desc_addr`, most significant byte first and MSB first within each byte. On one lane it drives IO0. On two lanes IO1 carries the higher bit and IO0 the lower. On four lanes IO3 to IO0 carry bits 7..4 and then 3..0. `io_oe` is 0001, 0011 or 1111 to match the width.
- R5: Each dummy byte lasts 8/width SCLK periods at the dummy lane width, and `io_oe`=0 throughout.
- R6: Output data bytes come from the transmit stream, one per `tx_valid`&`tx_ready` handshake, using the lane mapping of R4. While `tx_ready` is high, SCLK stays low.
- R7: Input data keeps `io_oe`=0. Bits are sampled at each SCLK rising edge: IO1 on one lane, IO1:IO0 on two lanes, IO3:IO0 on four lanes, MSB first. Each completed byte raises `rx_valid` for one cycle with the byte on `rx_data`.
- R8: Lane outputs and enables never change at a rising SCLK edge. Every SCLK high time is `CLK_DIV` clocks.
- R9: `spi_cs_n` is low whenever SCLK is high or any lane is driven. `done` pulses once per operation, in the cycle `spi_cs_n` rises. `spi_cs_n` then stays high for at least 2*`CLK_DIV` clocks.
- R10: `desc_ready` is high only while `spi_cs_n` is high and no operation is in progress. It goes low right after a descriptor is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Framer idle and able to accept a descriptor |
| desc_opcode | input | 8 | Command byte |
| desc_addr | input | 24 | Address, right-aligned |
| desc_addr_bytes | input | 2 | Address byte count, 0 to 3 |
| desc_addr_lanes | input | 2 | Address lane-width code |
| desc_dummy_bytes | input | DUMMY_W | Dummy byte count |
| desc_dummy_lanes | input | 2 | Dummy lane-width code |
| desc_data_in | input | 1 | 1 = data phase receives, 0 = sends |
| desc_data_len | input | LEN_W | Data byte count |
| desc_data_lanes | input | 2 | Data lane-width code |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Framer takes the transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| done | output | 1 | Operation finished, pulses with chip-select release |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Lane output values, zero where not enabled |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
A wrong byte or beat count inside the sequencer shows up at once as a missing or extra SCLK rising edge. It also shows up as a shift in every lane value that follows, so the first bad beat pins the fault to a phase. A wrong phase decision shows within one SCLK period, as an enable asserted during a dummy or input byte or as a lane mask of the wrong width. Sampling faults on the receive path stay hidden until a byte completes, and then appear in the `rx_valid` byte at most 8 SCLK periods later. A framing or guard fault is seen at the release of chip select, through `done` and the idle gap that follows.

// File: rtl/spi_op_pkg.sv
package spi_op_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_TAIL  = 3'd4,
    ST_GUARD = 3'd5
  } state_e;

  // lane enable pattern for a width code
  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // SCLK periods needed for one byte at a width code
  function automatic logic [3:0] beats_per_byte(input logic [1:0] code);
    case (code)
      2'd0:    beats_per_byte = 4'd8;
      2'd1:    beats_per_byte = 4'd4;
      default: beats_per_byte = 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_sel,
  output logic tick
);
  localparam int TW = $clog2(2 * CLK_DIV + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit = long_sel ? TW'(2 * CLK_DIV) : TW'(CLK_DIV);
  assign tick  = run && (cnt == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + TW'(1);
  end

  // a running count never passes the selected window
  assert_count_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       sample,
  input  logic [1:0] lanes,
  input  logic [3:0] io_in,
  output logic [3:0] drive_bits,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sr;
  logic [7:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_byte;
    end else if (shift) begin
      case (lanes)
        2'd0:    tx_sr <= {tx_sr[6:0], 1'b0};
        2'd1:    tx_sr <= {tx_sr[5:0], 2'b00};
        default: tx_sr <= {tx_sr[3:0], 4'b0000};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
    end else if (sample) begin
      case (lanes)
        2'd0:    rx_sr <= {rx_sr[6:0], io_in[1]};
        2'd1:    rx_sr <= {rx_sr[5:0], io_in[1:0]};
        default: rx_sr <= {rx_sr[3:0], io_in[3:0]};
      endcase
    end
  end

  always_comb begin
    case (lanes)
      2'd0:    drive_bits = {3'b000, tx_sr[7]};
      2'd1:    drive_bits = {2'b00, tx_sr[7:6]};
      default: drive_bits = tx_sr[7:4];
    endcase
  end

  assign rx_byte = rx_sr;

endmodule

// File: rtl/spi_op_sequencer.sv
module spi_op_sequencer
  import spi_op_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int DUMMY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [7:0]         desc_opcode,
  input  logic [23:0]        desc_addr,
  input  logic [1:0]         desc_addr_bytes,
  input  logic [1:0]         desc_addr_lanes,
  input  logic [DUMMY_W-1:0] desc_dummy_bytes,
  input  logic [1:0]         desc_dummy_lanes,
  input  logic               desc_data_in,
  input  logic [LEN_W-1:0]   desc_data_len,
  input  logic [1:0]         desc_data_lanes,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [7:0]         tx_data,
  input  logic               tick,
  output logic               timer_run,
  output logic               timer_long,
  output logic               load,
  output logic [7:0]         load_byte,
  output logic               shift,
  output logic               sample,
  output logic [1:0]         lanes,
  output logic [3:0]         oe,
  output logic               rx_valid,
  output logic               sclk,
  output logic               cs_n,
  output logic               done
);
  localparam int CW0 = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W;
  localparam int CW  = (CW0 > 2) ? CW0 : 2;

  state_e              state;
  phase_e              phase;
  logic [CW-1:0]       bytes_left;
  logic [3:0]          beats_left;

  logic [7:0]          r_op;
  logic [23:0]         r_addr;
  logic [1:0]          r_abytes;
  logic [1:0]          r_alanes;
  logic [DUMMY_W-1:0]  r_dummy;
  logic [1:0]          r_dlanes;
  logic                r_din;
  logic [LEN_W-1:0]    r_len;
  logic [1:0]          r_dtlanes;

  phase_e              nxt_ph;
  logic [CW-1:0]       nxt_cnt;
  logic                nxt_ok;
  logic                needs_tx;
  logic                drives;

  // choose the next non-empty phase after the current one
  always_comb begin
    nxt_ok  = 1'b0;
    nxt_ph  = PH_DATA;
    nxt_cnt = '0;
    if (phase == PH_CMD && r_abytes != 2'd0) begin
      nxt_ok  = 1'b1;
      nxt_ph  = PH_ADDR;
      nxt_cnt = CW'(r_abytes);
    end else if ((phase == PH_CMD || phase == PH_ADDR) && r_dummy != '0) begin
      nxt_ok  = 1'b1;
      nxt_ph  = PH_DUMMY;
      nxt_cnt = CW'(r_dummy);
    end else if (phase != PH_DATA && r_len != '0) begin
      nxt_ok  = 1'b1;
      nxt_ph  = PH_DATA;
      nxt_cnt = CW'(r_len);
    end
  end

  always_comb begin
    case (phase)
      PH_CMD:   lanes = 2'd0;
      PH_ADDR:  lanes = r_alanes;
      PH_DUMMY: lanes = r_dlanes;
      default:  lanes = r_dtlanes;
    endcase
  end

  always_comb begin
    case (phase)
      PH_CMD:   load_byte = r_op;
      PH_ADDR:  load_byte = r_addr[23:16];
      PH_DUMMY: load_byte = 8'h00;
      default:  load_byte = r_din ? 8'h00 : tx_data;
    endcase
  end

  assign needs_tx   = (phase == PH_DATA) && !r_din;
  assign drives     = (phase != PH_DUMMY) && !((phase == PH_DATA) && r_din);
  assign desc_ready = (state == ST_IDLE);
  assign tx_ready   = (state == ST_LOAD) && needs_tx;
  assign load       = (state == ST_LOAD) && (!needs_tx || tx_valid);
  assign shift      = (state == ST_HIGH) && tick && (beats_left > 4'd1);
  assign sample     = (state == ST_LOW) && tick && (phase == PH_DATA) && r_din;
  assign timer_run  = (state == ST_LOW) || (state == ST_HIGH) ||
                      (state == ST_TAIL) || (state == ST_GUARD);
  assign timer_long = (state == ST_GUARD);
  assign oe = (drives && ((state == ST_LOAD) || (state == ST_LOW) || (state == ST_HIGH)))
              ? lane_mask(lanes) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= PH_CMD;
      bytes_left <= '0;
      beats_left <= '0;
      r_op       <= '0;
      r_addr     <= '0;
      r_abytes   <= '0;
      r_alanes   <= '0;
      r_dummy    <= '0;
      r_dlanes   <= '0;
      r_din      <= 1'b0;
      r_len      <= '0;
      r_dtlanes  <= '0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      done       <= 1'b0;
      rx_valid   <= 1'b0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (desc_valid) begin
            r_op      <= desc_opcode;
            r_abytes  <= desc_addr_bytes;
            r_alanes  <= desc_addr_lanes;
            r_dummy   <= desc_dummy_bytes;
            r_dlanes  <= desc_dummy_lanes;
            r_din     <= desc_data_in;
            r_len     <= desc_data_len;
            r_dtlanes <= desc_data_lanes;
            case (desc_addr_bytes)
              2'd1:    r_addr <= {desc_addr[7:0], 16'h0000};
              2'd2:    r_addr <= {desc_addr[15:0], 8'h00};
              default: r_addr <= desc_addr;
            endcase
            phase      <= PH_CMD;
            bytes_left <= CW'(1);
            cs_n       <= 1'b0;
            state      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (load) begin
            beats_left <= beats_per_byte(lanes);
            if (phase == PH_ADDR) r_addr <= {r_addr[15:0], 8'h00};
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk     <= 1'b1;
            rx_valid <= sample && (beats_left == 4'd1);
            state    <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (beats_left > 4'd1) begin
              beats_left <= beats_left - 4'd1;
              state      <= ST_LOW;
            end else if (bytes_left > CW'(1)) begin
              bytes_left <= bytes_left - CW'(1);
              state      <= ST_LOAD;
            end else if (nxt_ok) begin
              phase      <= nxt_ph;
              bytes_left <= nxt_cnt;
              state      <= ST_LOAD;
            end else begin
              state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (tick) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // clock edges only inside a frame
  assert_sclk_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // completion coincides with the release of chip select
  assert_done_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));

  // a new descriptor is only taken outside a frame
  assert_ready_outside_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> cs_n);

  // waiting on transmit data never leaves the clock high
  assert_stall_clock_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!sclk && !cs_n));

  // lane enables do not move during a high clock phase
  assert_oe_stable_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(oe));

endmodule

// File: rtl/spi_op_framer.sv
module spi_op_framer #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 8,
  parameter int DUMMY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [7:0]         desc_opcode,
  input  logic [23:0]        desc_addr,
  input  logic [1:0]         desc_addr_bytes,
  input  logic [1:0]         desc_addr_lanes,
  input  logic [DUMMY_W-1:0] desc_dummy_bytes,
  input  logic [1:0]         desc_dummy_lanes,
  input  logic               desc_data_in,
  input  logic [LEN_W-1:0]   desc_data_len,
  input  logic [1:0]         desc_data_lanes,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [7:0]         tx_data,
  output logic               rx_valid,
  output logic [7:0]         rx_data,
  output logic               done,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in
);
  logic       tick;
  logic       timer_run;
  logic       timer_long;
  logic       load;
  logic [7:0] load_byte;
  logic       shift;
  logic       sample;
  logic [1:0] lanes;
  logic [3:0] oe;
  logic [3:0] drive_bits;

  spi_half_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (timer_run),
    .long_sel (timer_long),
    .tick     (tick)
  );

  spi_op_sequencer #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .desc_valid       (desc_valid),
    .desc_ready       (desc_ready),
    .desc_opcode      (desc_opcode),
    .desc_addr        (desc_addr),
    .desc_addr_bytes  (desc_addr_bytes),
    .desc_addr_lanes  (desc_addr_lanes),
    .desc_dummy_bytes (desc_dummy_bytes),
    .desc_dummy_lanes (desc_dummy_lanes),
    .desc_data_in     (desc_data_in),
    .desc_data_len    (desc_data_len),
    .desc_data_lanes  (desc_data_lanes),
    .tx_valid         (tx_valid),
    .tx_ready         (tx_ready),
    .tx_data          (tx_data),
    .tick             (tick),
    .timer_run        (timer_run),
    .timer_long       (timer_long),
    .load             (load),
    .load_byte        (load_byte),
    .shift            (shift),
    .sample           (sample),
    .lanes            (lanes),
    .oe               (oe),
    .rx_valid         (rx_valid),
    .sclk             (spi_sclk),
    .cs_n             (spi_cs_n),
    .done             (done)
  );

  spi_lane_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_byte  (load_byte),
    .shift      (shift),
    .sample     (sample),
    .lanes      (lanes),
    .io_in      (io_in),
    .drive_bits (drive_bits),
    .rx_byte    (rx_data)
  );

  assign io_oe  = oe;
  assign io_out = drive_bits & oe;

  // a received byte is never reported while lanes are driven
  assert_rx_lanes_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (io_oe == 4'b0000));

  // lanes are only driven inside a frame
  assert_drive_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'b0000) |-> !spi_cs_n);

endmodule

// File: tb/spi_op_framer_tb.sv
module spi_op_framer_tb;
  localparam int CLK_DIV = 2;
  localparam int LEN_W   = 8;
  localparam int DUMMY_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               desc_valid = 1'b0;
  logic               desc_ready;
  logic [7:0]         desc_opcode = '0;
  logic [23:0]        desc_addr = '0;
  logic [1:0]         desc_addr_bytes = '0;
  logic [1:0]         desc_addr_lanes = '0;
  logic [DUMMY_W-1:0] desc_dummy_bytes = '0;
  logic [1:0]         desc_dummy_lanes = '0;
  logic               desc_data_in = 1'b0;
  logic [LEN_W-1:0]   desc_data_len = '0;
  logic [1:0]         desc_data_lanes = '0;
  logic               tx_valid = 1'b0;
  logic               tx_ready;
  logic [7:0]         tx_data = '0;
  logic               rx_valid;
  logic [7:0]         rx_data;
  logic               done;
  logic               spi_sclk;
  logic               spi_cs_n;
  logic [3:0]         io_out;
  logic [3:0]         io_oe;
  logic [3:0]         io_in = '0;

  spi_op_framer #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_opcode(desc_opcode), .desc_addr(desc_addr),
    .desc_addr_bytes(desc_addr_bytes), .desc_addr_lanes(desc_addr_lanes),
    .desc_dummy_bytes(desc_dummy_bytes), .desc_dummy_lanes(desc_dummy_lanes),
    .desc_data_in(desc_data_in), .desc_data_len(desc_data_len),
    .desc_data_lanes(desc_data_lanes),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- pin monitor and stream drivers ----------------
  logic [3:0] rec_out [0:255];
  logic [3:0] rec_oe  [0:255];
  logic [7:0] rx_rec  [0:15];
  int  beat_n = 0, rx_n = 0, hi_cnt = 0, done_n = 0, cs_hi = 1000;
  int  tx_idx = 0, tx_total = 0, cyc = 0;
  int  op_seed = 0;
  bit  stall_en = 0, fire_pend = 0, clear_req = 0;
  bit  mode0_bad = 0, hi_bad = 0, frame_bad = 0, done_bad = 0, gap_bad = 0;
  bit  stall_bad = 0, ready_bad = 0;
  logic       prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [7:0] prev_pins = '0;

  function automatic logic [3:0] pat(input int k, input int seed);
    return 4'((k * 5 + seed * 3 + 1) & 15);
  endfunction

  function automatic logic [7:0] txb(input int i, input int seed);
    return 8'((8'h3C ^ (i * 29)) + seed);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (clear_req) begin
      beat_n = 0; rx_n = 0; hi_cnt = 0; done_n = 0;
      tx_idx = 0; fire_pend = 0;
      mode0_bad = 0; hi_bad = 0; frame_bad = 0; done_bad = 0; gap_bad = 0;
      stall_bad = 0; ready_bad = 0;
      clear_req = 0;
    end
    if (rst_n) begin
      if (spi_sclk && !prev_sclk) begin
        if (beat_n < 256) begin
          rec_out[beat_n] = io_out;
          rec_oe[beat_n]  = io_oe;
        end
        if (prev_pins != {io_oe, io_out}) mode0_bad = 1;
        beat_n++;
      end
      if (spi_sclk) hi_cnt++;
      else begin
        if (prev_sclk && hi_cnt != CLK_DIV) hi_bad = 1;
        hi_cnt = 0;
      end
      if (spi_sclk && spi_cs_n) frame_bad = 1;
      if (io_oe != 4'b0 && spi_cs_n) frame_bad = 1;
      if (done) begin
        done_n++;
        if (!(spi_cs_n && !prev_cs)) done_bad = 1;
      end
      if (spi_cs_n) cs_hi++;
      else begin
        if (prev_cs && cs_hi < 2 * CLK_DIV) gap_bad = 1;
        cs_hi = 0;
      end
      if (tx_ready && spi_sclk) stall_bad = 1;
      if (desc_ready && !spi_cs_n) ready_bad = 1;
      if (rx_valid && rx_n < 16) begin rx_rec[rx_n] = rx_data; rx_n++; end
      if (fire_pend) tx_idx++;
      tx_valid = (tx_idx < tx_total) && (!stall_en || (cyc % 4 == 0));
      tx_data  = txb(tx_idx, op_seed);
      fire_pend = tx_valid && tx_ready;
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
      prev_pins = {io_oe, io_out};
    end
    io_in = pat(beat_n, op_seed);
  end

  // ---------------- expected beat model ----------------
  logic [3:0] exp_out [0:255];
  logic [3:0] exp_oe  [0:255];
  int         exp_ph  [0:255];
  logic [7:0] exp_rx  [0:15];
  int exp_n = 0, exp_rx_n = 0;

  function automatic int width_of(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  // kind: 0 drive, 1 released dummy, 2 receive
  task automatic add_byte(input logic [7:0] b, input logic [1:0] code,
                          input int kind, input int ph);
    int w = width_of(code);
    logic [7:0] acc = '0;
    for (int k = 0; k < 8 / w; k++) begin
      logic [3:0] m = 4'((1 << w) - 1);
      logic [3:0] bits = 4'((b >> (8 - w * (k + 1))) & m);
      exp_ph[exp_n] = ph;
      if (kind == 0) begin
        exp_oe[exp_n]  = m;
        exp_out[exp_n] = bits;
      end else begin
        exp_oe[exp_n]  = 4'b0;
        exp_out[exp_n] = 4'b0;
      end
      if (kind == 2) begin
        logic [3:0] pv = pat(exp_n, op_seed);
        if (w == 1)      acc = {acc[6:0], pv[1]};
        else if (w == 2) acc = {acc[5:0], pv[1:0]};
        else             acc = {acc[3:0], pv};
      end
      exp_n++;
    end
    if (kind == 2) begin exp_rx[exp_rx_n] = acc; exp_rx_n++; end
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [23:0] addr,
                        input int ab, input logic [1:0] al,
                        input int dm, input logic [1:0] dl,
                        input bit din, input int len, input logic [1:0] dtl,
                        input bit stall, input string tag);
    int wait_n = 0;
    op_seed  = int'(opc) + ab * 7 + len;
    stall_en = stall;
    tx_total = din ? 0 : len;
    exp_n = 0; exp_rx_n = 0;
    add_byte(opc, 2'd0, 0, 0);
    for (int i = ab - 1; i >= 0; i--) add_byte(8'(addr >> (8 * i)), al, 0, 1);
    for (int i = 0; i < dm; i++) add_byte(8'h00, dl, 1, 2);
    for (int i = 0; i < len; i++)
      add_byte(din ? 8'h00 : txb(i, op_seed), dtl, din ? 2 : 0, 3);

    clear_req = 1;
    @(negedge clk); @(negedge clk);
    desc_opcode = opc; desc_addr = addr; desc_addr_bytes = 2'(ab);
    desc_addr_lanes = al; desc_dummy_bytes = DUMMY_W'(dm); desc_dummy_lanes = dl;
    desc_data_in = din; desc_data_len = LEN_W'(len); desc_data_lanes = dtl;
    desc_valid = 1'b1;
    while (!desc_ready && wait_n < 100) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    desc_valid = 1'b0;
    desc_addr = 24'hFFFFFF; desc_opcode = 8'h00; // host may change fields after acceptance
    chk(desc_ready == 1'b0, "R10", {tag, " ready after accept"}, desc_ready, 0);
    wait_n = 0;
    while (done_n == 0 && wait_n < 5000) begin @(negedge clk); wait_n++; end
    @(negedge clk);

    chk(beat_n == exp_n, "R2", {tag, " sclk rising edges"}, beat_n, exp_n);
    begin
      bit bad [0:3];
      int fa [0:3];
      int fe [0:3];
      bit seen [0:3];
      for (int p = 0; p < 4; p++) begin bad[p] = 0; seen[p] = 0; fa[p] = 0; fe[p] = 0; end
      for (int k = 0; k < exp_n && k < beat_n; k++) begin
        int p = exp_ph[k];
        seen[p] = 1;
        if (!bad[p] && (rec_oe[k] !== exp_oe[k] || rec_out[k] !== exp_out[k])) begin
          bad[p] = 1;
          fa[p] = {rec_oe[k], rec_out[k]};
          fe[p] = {exp_oe[k], exp_out[k]};
        end
      end
      if (seen[0]) chk(!bad[0], "R3", {tag, " command lanes {oe,out}"}, fa[0], fe[0]);
      if (seen[1]) chk(!bad[1], "R4", {tag, " address lanes {oe,out}"}, fa[1], fe[1]);
      if (seen[2]) chk(!bad[2], "R5", {tag, " dummy lanes {oe,out}"}, fa[2], fe[2]);
      if (seen[3]) chk(!bad[3], din ? "R7" : "R6", {tag, " data lanes {oe,out}"}, fa[3], fe[3]);
    end
    if (din) begin
      chk(rx_n == len, "R7", {tag, " received byte count"}, rx_n, len);
      for (int i = 0; i < len && i < rx_n; i++)
        chk(rx_rec[i] == exp_rx[i], "R7", {tag, " received byte"}, rx_rec[i], exp_rx[i]);
    end else begin
      chk(tx_idx == len, "R6", {tag, " transmit handshakes"}, tx_idx, len);
    end
    chk(!stall_bad, "R6", {tag, " sclk low while waiting for tx"}, stall_bad, 0);
    chk(!mode0_bad && !hi_bad, "R8", {tag, " edge timing"}, {mode0_bad, hi_bad}, 0);
    chk(!frame_bad && !gap_bad, "R9", {tag, " framing and guard"}, {frame_bad, gap_bad}, 0);
    chk(done_n == 1 && !done_bad, "R9", {tag, " done pulses"}, done_n, 1);
    chk(!ready_bad, "R10", {tag, " ready only while idle"}, ready_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && io_oe == 4'b0 && done == 1'b0 &&
        rx_valid == 1'b0 && desc_ready == 1'b1,
        "R1", "outputs during reset",
        {spi_cs_n, spi_sclk, io_oe, done, rx_valid, desc_ready}, 9'b1_0_0000_0_0_1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && io_oe == 4'b0 && desc_ready == 1'b1,
        "R1", "outputs after reset",
        {spi_cs_n, spi_sclk, io_oe, desc_ready}, 7'b1_0_0000_1);

    // named forms
    run_op(8'h06, 24'h0, 0, 2'd0, 0, 2'd0, 1'b0, 0, 2'd0, 1'b0, "R2 command only");
    run_op(8'hEB, 24'h00_1A2B, 2, 2'd2, 2, 2'd2, 1'b1, 4, 2'd2, 1'b0, "R4 quad io read");
    run_op(8'h6B, 24'h00_0C3D, 2, 2'd0, 1, 2'd0, 1'b1, 3, 2'd2, 1'b0, "R7 x4 output read");
    run_op(8'h32, 24'h00_0081, 2, 2'd3, 0, 2'd0, 1'b0, 2, 2'd3, 1'b0, "R4 code 3 quad");
    run_op(8'h02, 24'h00_0100, 2, 2'd0, 0, 2'd0, 1'b0, 4, 2'd0, 1'b1, "R6 stalled write");
    run_op(8'h34, 24'h00_0200, 2, 2'd1, 0, 2'd0, 1'b0, 3, 2'd2, 1'b1, "R6 stalled quad write");
    run_op(8'h9F, 24'h0, 0, 2'd0, 1, 2'd1, 1'b1, 2, 2'd0, 1'b0, "R5 dummy without address");

    // sweep of address width, address length, data width and direction
    for (int al = 0; al < 3; al++)
      for (int ab = 0; ab < 4; ab++)
        for (int dtl = 0; dtl < 3; dtl++)
          for (int din = 0; din < 2; din++)
            run_op(8'(8'h40 + al * 16 + ab * 4 + dtl), 24'h5A_C3_96 ^ 24'(ab * 4097),
                   ab, 2'(al), (ab + dtl) % 3, 2'(al), din[0],
                   1 + (al + ab) % 3, 2'(dtl), 1'b0, "R2 sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule